// File: doc/BRIEF.md
# Serial Flash Protocol Mode Controller

This block is the device-side command front end of a serial NOR flash. A host frames every instruction with an active-low chip select and clocks it in on a serial clock. The block samples those pins with its own system clock and detects the serial clock edges. It assembles each instruction byte and passes the opcode to downstream logic as a one-cycle strobe. It also tracks which bus protocol is in force. In the single-line state, instructions arrive one bit per clock. In the four-line state, they arrive one nibble per clock.

The block also decodes the control instructions itself. One opcode enters the four-line state and another leaves it. A two-frame software reset (arm, then execute) sends the device back through an initialization period, after which it is in the single-line state again. Downstream logic can hand the block a response byte. The block shifts that byte out on falling serial clock edges, on one line or on four, and drives the per-line output enables to match. Hosts that idle the serial clock low and hosts that idle it high both work, with no setting to choose between them.

Top module: `sfm_proto_ctrl`

## Requirements
- R1: While `rst` is high and for the first INIT_CYCLES system clocks after it, `mode_o` reads 0 (initializing), `io_oe` is 0 and `op_stb` stays low. After that, `mode_o` reads 1 (single-line). Mode encoding: 0 = initializing, 1 = single-line, 2 = four-line; 3 never appears.
- R2: In the single-line state, a frame's first 8 rising serial clock edges sample `io_in[0]`, most significant bit first. After the eighth edge, `op_stb` pulses high for exactly one system clock, and `op_code` holds the byte during that pulse.
- R3: In the four-line state, a frame's first 2 rising edges sample `io_in[3:0]`, upper nibble first, and the block strobes the byte as in R2.
- R4: Opcode 38h received in the single-line state switches `mode_o` to 2. Opcode 38h received in the four-line state leaves the mode unchanged.
- R5: Opcode FFh received in the four-line state switches `mode_o` to 1. Opcode FFh received in the single-line state leaves the mode unchanged.
- R6: Opcode 66h followed by opcode 99h as the next complete instruction returns `mode_o` to 0 from either the single-line or the four-line state. R1 timing then applies again, ending in mode 1.
- R7: The arm set by 66h is dropped by any other complete instruction. So 66h, then another opcode, then 99h causes no reset, and a 99h without a preceding 66h has no effect.
- R8: If chip select rises before a whole byte has arrived, the partial bits are discarded: no strobe occurs, and the next frame starts a fresh byte.
- R9: Capture is the same whether the serial clock idles low or idles high at the chip-select edges.
- R10: Rising edges after the instruction byte within the same frame produce no further strobe and no mode change.
- R11: After a `rsp_load` pulse in a selected frame, each following falling serial clock edge drives the next part of `rsp_byte`, most significant first. The single-line state drives one bit on `io_out[1]` with `io_oe` = 4'b0010. The four-line state drives one nibble on `io_out[3:0]` with `io_oe` = 4'b1111. The falling edge after the last part sets `io_oe` to 0, and chip select going high clears it too.
- R12: Instructions clocked in while `mode_o` is 0 give no strobe and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select; one instruction per low period |
| io_in | input | 4 | Sampled data lines; only bit 0 is used in the single-line state |
| io_out | output | 4 | Response data to drive onto the lines |
| io_oe | output | 4 | Per-line output enable for `io_out` |
| rsp_load | input | 1 | One-cycle pulse that hands a response byte to the shifter |
| rsp_byte | input | 8 | Response byte, sampled when `rsp_load` is high |
| op_stb | output | 1 | One-cycle pulse when an instruction byte is complete |
| op_code | output | 8 | Decoded instruction byte, valid with `op_stb` |
| mode_o | output | 2 | Current protocol state, encoded as in R1 |

## Verification
The properties assume that each serial clock level lasts several system clocks, so that every edge survives the synchronizer as one distinct event. They also assume that `io_in` is stable at each rising edge and that `rsp_load` comes only after the instruction byte of the same frame. The bench holds every serial clock phase for six system clocks, and it changes data only while the clock is low. It pulses the load only when the opcode strobe for the frame has been seen, and it covers both clock idle levels.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,
        MODE_SPI  = 2'd1,
        MODE_QPI  = 2'd2
    } mode_e;

    localparam logic [BYTE_W-1:0] OP_QUAD_ON  = 8'h38;
    localparam logic [BYTE_W-1:0] OP_QUAD_OFF = 8'hFF;
    localparam logic [BYTE_W-1:0] OP_RST_ARM  = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RST_GO   = 8'h99;

    typedef struct packed {
        logic             cs_act;
        logic             rise;
        logic             fall;
        logic [LANES-1:0] io;
    } pin_evt_t;

    function automatic logic [3:0] lane_bits(input logic quad);
        return quad ? 4'd4 : 4'd1;
    endfunction

endpackage

// File: rtl/sfm_pin_sync.sv
module sfm_pin_sync
    import sfm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck,
    input  logic             cs_n,
    input  logic [LANES-1:0] io,
    output pin_evt_t         evt
);
    localparam int PW = LANES + 2;
    localparam logic [PW-1:0] IDLE = PW'(1) << LANES;

    logic [STAGES-1:0][PW-1:0] chain;
    logic [PW-1:0]             tail;
    logic                      sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE;
            sck_prev <= 1'b0;
        end else begin
            chain[0] <= {sck, cs_n, io};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_prev <= tail[PW-1];
        end
    end

    assign tail       = chain[STAGES-1];
    assign evt.cs_act = ~tail[LANES];
    assign evt.rise   = tail[PW-1] & ~sck_prev & ~tail[LANES];
    assign evt.fall   = ~tail[PW-1] & sck_prev & ~tail[LANES];
    assign evt.io     = tail[LANES-1:0];

endmodule

// File: rtl/sfm_cmd_shift.sv
module sfm_cmd_shift
    import sfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              rise,
    input  logic [LANES-1:0]  io,
    input  logic              enable,
    input  logic              quad,
    output logic              stb,
    output logic [BYTE_W-1:0] code
);
    localparam logic [3:0] FULL = 4'(BYTE_W);

    logic [BYTE_W-1:0] sreg, sreg_nxt;
    logic [3:0]        cnt, cnt_nxt;

    always_comb begin
        sreg_nxt = quad ? {sreg[BYTE_W-LANES-1:0], io} : {sreg[BYTE_W-2:0], io[0]};
        cnt_nxt  = cnt + lane_bits(quad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            cnt  <= '0;
            stb  <= 1'b0;
            code <= '0;
        end else begin
            stb <= 1'b0;
            if (!cs_act || !enable) begin
                cnt <= '0;
            end else if (rise && cnt < FULL) begin
                sreg <= sreg_nxt;
                cnt  <= cnt_nxt;
                if (cnt_nxt == FULL) begin
                    stb  <= 1'b1;
                    code <= sreg_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/sfm_mode_fsm.sv
module sfm_mode_fsm
    import sfm_pkg::*;
#(
    parameter int INIT_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [BYTE_W-1:0] code,
    output mode_e             mode
);
    localparam int CW = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] init_cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_INIT;
            init_cnt <= '0;
            armed    <= 1'b0;
        end else if (mode == MODE_INIT) begin
            armed <= 1'b0;
            if (init_cnt == LAST) begin
                mode     <= MODE_SPI;
                init_cnt <= '0;
            end else begin
                init_cnt <= init_cnt + 1'b1;
            end
        end else if (stb) begin
            if (armed && code == OP_RST_GO) begin
                mode     <= MODE_INIT;
                init_cnt <= '0;
                armed    <= 1'b0;
            end else begin
                armed <= (code == OP_RST_ARM);
                if (mode == MODE_SPI && code == OP_QUAD_ON)
                    mode <= MODE_QPI;
                else if (mode == MODE_QPI && code == OP_QUAD_OFF)
                    mode <= MODE_SPI;
            end
        end
    end

endmodule

// File: rtl/sfm_tx_shift.sv
module sfm_tx_shift
    import sfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              fall,
    input  logic              quad,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [LANES-1:0]  out,
    output logic [LANES-1:0]  oe
);
    logic [BYTE_W-1:0] sh;
    logic [3:0]        left;
    logic              pend;
    logic              wide;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            sh   <= '0;
            left <= '0;
            pend <= 1'b0;
            wide <= 1'b0;
            out  <= '0;
            oe   <= '0;
        end else if (load) begin
            sh   <= load_byte;
            pend <= 1'b1;
            wide <= quad;
            left <= '0;
        end else if (fall) begin
            if (pend || left != 0) begin
                if (wide) begin
                    out <= sh[BYTE_W-1 -: LANES];
                    oe  <= '1;
                    sh  <= sh << LANES;
                end else begin
                    out <= {2'b00, sh[BYTE_W-1], 1'b0};
                    oe  <= 4'b0010;
                    sh  <= sh << 1;
                end
                left <= (pend ? 4'(BYTE_W) : left) - lane_bits(wide);
                pend <= 1'b0;
            end else begin
                out <= '0;
                oe  <= '0;
            end
        end
    end

endmodule

// File: rtl/sfm_proto_ctrl.sv
module sfm_proto_ctrl
    import sfm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int INIT_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_clk,
    input  logic        spi_cs_n,
    input  logic [3:0]  io_in,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic        rsp_load,
    input  logic [7:0]  rsp_byte,
    output logic        op_stb,
    output logic [7:0]  op_code,
    output logic [1:0]  mode_o
);
    pin_evt_t evt;
    mode_e    mode;
    logic     cs_live;
    logic     quad;
    logic     cap_en;

    sfm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .sck (spi_clk),
        .cs_n(spi_cs_n),
        .io  (io_in),
        .evt (evt)
    );

    assign cs_live = evt.cs_act;
    assign quad    = (mode == MODE_QPI);
    assign cap_en  = (mode != MODE_INIT);

    sfm_cmd_shift u_cmd (
        .clk   (clk),
        .rst   (rst),
        .cs_act(evt.cs_act),
        .rise  (evt.rise),
        .io    (evt.io),
        .enable(cap_en),
        .quad  (quad),
        .stb   (op_stb),
        .code  (op_code)
    );

    sfm_mode_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
        .clk (clk),
        .rst (rst),
        .stb (op_stb),
        .code(op_code),
        .mode(mode)
    );

    sfm_tx_shift u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (evt.cs_act),
        .fall     (evt.fall),
        .quad     (quad),
        .load     (rsp_load),
        .load_byte(rsp_byte),
        .out      (io_out),
        .oe       (io_oe)
    );

    assign mode_o = mode;

endmodule

// File: rtl/sfm_proto_ctrl_chk.sv
module sfm_proto_ctrl_chk
    import sfm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_live,
    input logic       op_stb,
    input logic [7:0] op_code,
    input logic [1:0] mode_o,
    input logic [3:0] io_oe
);
    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3);

    assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
        op_stb |=> !op_stb);

    assert_quad_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_QPI && $past(mode_o) == MODE_SPI)
            |-> $past(op_stb && op_code == OP_QUAD_ON));

    assert_quad_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_SPI && $past(mode_o) == MODE_QPI)
            |-> $past(op_stb && op_code == OP_QUAD_OFF));

    assert_reset_seq_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_INIT && $past(mode_o) != MODE_INIT)
            |-> $past(op_stb && op_code == OP_RST_GO));

    assert_oe_released_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_live |=> io_oe == 4'b0000);

    assert_oe_shape_R11: assert property (@(posedge clk) disable iff (rst)
        io_oe == 4'b0000 || io_oe == 4'b0010 || io_oe == 4'b1111);

    assert_no_stb_init_R12: assert property (@(posedge clk) disable iff (rst)
        op_stb |-> mode_o != MODE_INIT);

endmodule

bind sfm_proto_ctrl sfm_proto_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_live(cs_live),
    .op_stb (op_stb),
    .op_code(op_code),
    .mode_o (mode_o),
    .io_oe  (io_oe)
);

// File: tb/sfm_proto_ctrl_test.sv
module sfm_proto_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int INIT_CYC   = 256;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_clk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic [3:0] io_in = 4'h0;
    logic [3:0] io_out, io_oe;
    logic       rsp_load = 1'b0;
    logic [7:0] rsp_byte = 8'h00;
    logic       op_stb;
    logic [7:0] op_code;
    logic [1:0] mode_o;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    int cyc = 0;
    logic [7:0] last_op = 8'h00;

    sfm_proto_ctrl #(.INIT_CYCLES(INIT_CYC)) uut (
        .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .rsp_load(rsp_load), .rsp_byte(rsp_byte),
        .op_stb(op_stb), .op_code(op_code), .mode_o(mode_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (op_stb) begin
            stb_cnt <= stb_cnt + 1;
            last_op <= op_code;
        end
    end

    always @(negedge clk) begin
        if (cyc > WATCHDOG) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin(input bit idle_hi);
        spi_clk = idle_hi;
        wait_cyc(HALF);
        spi_cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic frame_end(input bit idle_hi);
        spi_clk = idle_hi;
        wait_cyc(HALF);
        spi_cs_n = 1'b1;
        wait_cyc(2*HALF);
    endtask

    task automatic clock_nibble(input logic [3:0] v);
        spi_clk = 1'b0;
        io_in = v;
        wait_cyc(HALF);
        spi_clk = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) clock_nibble({3'b000, b[i]});
    endtask

    task automatic put_byte(input logic [7:0] b, input bit quad);
        if (quad) begin
            clock_nibble(b[7:4]);
            clock_nibble(b[3:0]);
        end else begin
            put_bits(b, 8);
        end
    endtask

    task automatic send_op(input logic [7:0] b, input bit quad, input bit idle_hi);
        frame_begin(idle_hi);
        put_byte(b, quad);
        frame_end(idle_hi);
    endtask

    task automatic wait_ready();
        wait_cyc(INIT_CYC + 10);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk(mode_o == 2'd0, "R1 mode in reset", mode_o, 0);
        chk(io_oe == 4'h0, "R1 oe in reset", io_oe, 0);
        rst = 1'b0;
        wait_cyc(INIT_CYC / 2);
        chk(mode_o == 2'd0, "R1 mode during init", mode_o, 0);
        chk(stb_cnt == 0, "R1 no strobe during init", stb_cnt, 0);
        wait_cyc(INIT_CYC / 2 + 10);
        chk(mode_o == 2'd1, "R1 mode after init", mode_o, 1);
    endtask

    task automatic t_spi_capture();
        int s0 = stb_cnt;
        send_op(8'hA5, 1'b0, 1'b0);
        chk(stb_cnt == s0 + 1, "R2 one strobe", stb_cnt - s0, 1);
        chk(last_op == 8'hA5, "R2 opcode idle-low", last_op, 8'hA5);
        send_op(8'h3C, 1'b0, 1'b1);
        chk(last_op == 8'h3C, "R9 opcode idle-high", last_op, 8'h3C);
        chk(mode_o == 2'd1, "R2 mode unchanged", mode_o, 1);
    endtask

    task automatic t_partial();
        int s0 = stb_cnt;
        frame_begin(1'b0);
        put_bits(8'h38, 5);
        frame_end(1'b0);
        chk(stb_cnt == s0, "R8 no strobe on partial", stb_cnt - s0, 0);
        send_op(8'h5A, 1'b0, 1'b0);
        chk(last_op == 8'h5A, "R8 fresh byte after partial", last_op, 8'h5A);
        chk(mode_o == 2'd1, "R8 mode unchanged", mode_o, 1);
    endtask

    task automatic t_extra_edges();
        int s0 = stb_cnt;
        frame_begin(1'b0);
        put_byte(8'h12, 1'b0);
        put_byte(8'h38, 1'b0);
        frame_end(1'b0);
        chk(stb_cnt == s0 + 1, "R10 single strobe", stb_cnt - s0, 1);
        chk(last_op == 8'h12, "R10 first byte kept", last_op, 8'h12);
        chk(mode_o == 2'd1, "R10 trailing 38h ignored", mode_o, 1);
    endtask

    task automatic t_quad_switch();
        send_op(8'hFF, 1'b0, 1'b0);
        chk(mode_o == 2'd1, "R5 FFh in single-line", mode_o, 1);
        send_op(8'h38, 1'b0, 1'b0);
        chk(mode_o == 2'd2, "R4 enter four-line", mode_o, 2);
        send_op(8'h38, 1'b1, 1'b0);
        chk(mode_o == 2'd2, "R4 38h in four-line", mode_o, 2);
        send_op(8'hC3, 1'b1, 1'b1);
        chk(last_op == 8'hC3, "R3 nibble capture", last_op, 8'hC3);
    endtask

    task automatic t_tx_quad();
        frame_begin(1'b1);
        put_byte(8'h0B, 1'b1);
        wait_cyc(2);
        rsp_byte = 8'h3C;
        rsp_load = 1'b1;
        wait_cyc(1);
        rsp_load = 1'b0;
        chk(io_oe == 4'h0, "R11 oe before first fall", io_oe, 0);
        spi_clk = 1'b0;
        wait_cyc(HALF);
        chk(io_oe == 4'hF && io_out == 4'h3, "R11 quad upper nibble", {io_oe, io_out}, 8'hF3);
        spi_clk = 1'b1;
        wait_cyc(HALF);
        spi_cs_n = 1'b1;
        wait_cyc(HALF);
        chk(io_oe == 4'h0, "R11 oe cleared by deselect", io_oe, 0);
        wait_cyc(HALF);
        frame_begin(1'b1);
        put_byte(8'h0B, 1'b1);
        rsp_load = 1'b1;
        wait_cyc(1);
        rsp_load = 1'b0;
        for (int k = 0; k < 3; k++) begin
            spi_clk = 1'b0;
            wait_cyc(HALF);
            if (k == 0)
                chk(io_oe == 4'hF && io_out == 4'h3, "R11 quad nibble 0", {io_oe, io_out}, 8'hF3);
            else if (k == 1)
                chk(io_oe == 4'hF && io_out == 4'hC, "R11 quad nibble 1", {io_oe, io_out}, 8'hFC);
            else
                chk(io_oe == 4'h0, "R11 quad release", io_oe, 0);
            spi_clk = 1'b1;
            wait_cyc(HALF);
        end
        frame_end(1'b1);
        send_op(8'hFF, 1'b1, 1'b0);
        chk(mode_o == 2'd1, "R5 leave four-line", mode_o, 1);
    endtask

    task automatic t_tx_single();
        logic [7:0] v = 8'hA5;
        frame_begin(1'b0);
        put_byte(8'h05, 1'b0);
        wait_cyc(2);
        rsp_byte = v;
        rsp_load = 1'b1;
        wait_cyc(1);
        rsp_load = 1'b0;
        for (int k = 0; k < 9; k++) begin
            spi_clk = 1'b0;
            wait_cyc(HALF);
            if (k < 8)
                chk(io_oe == 4'b0010 && io_out[1] == v[7-k], "R11 serial bit",
                    {io_oe, 3'b000, io_out[1]}, {4'b0010, 3'b000, v[7-k]});
            else
                chk(io_oe == 4'h0, "R11 serial release", io_oe, 0);
            spi_clk = 1'b1;
            wait_cyc(HALF);
        end
        frame_end(1'b0);
    endtask

    task automatic t_reset_broken();
        send_op(8'h66, 1'b0, 1'b0);
        send_op(8'h05, 1'b0, 1'b0);
        send_op(8'h99, 1'b0, 1'b0);
        wait_cyc(4);
        chk(mode_o == 2'd1, "R7 interrupted arm", mode_o, 1);
        send_op(8'h99, 1'b0, 1'b1);
        wait_cyc(4);
        chk(mode_o == 2'd1, "R7 lone 99h", mode_o, 1);
    endtask

    task automatic t_reset_single();
        int s0;
        send_op(8'h66, 1'b0, 1'b0);
        send_op(8'h99, 1'b0, 1'b0);
        chk(mode_o == 2'd0, "R6 reset from single-line", mode_o, 0);
        s0 = stb_cnt;
        send_op(8'h38, 1'b0, 1'b0);
        chk(stb_cnt == s0, "R12 no strobe while init", stb_cnt - s0, 0);
        chk(mode_o == 2'd0, "R12 still init", mode_o, 0);
        wait_ready();
        chk(mode_o == 2'd1, "R12 38h during init ignored", mode_o, 1);
    endtask

    task automatic t_reset_quad();
        send_op(8'h38, 1'b0, 1'b1);
        chk(mode_o == 2'd2, "R4 enter four-line again", mode_o, 2);
        send_op(8'h66, 1'b1, 1'b1);
        send_op(8'h99, 1'b1, 1'b1);
        chk(mode_o == 2'd0, "R6 reset from four-line", mode_o, 0);
        wait_ready();
        chk(mode_o == 2'd1, "R6 back to single-line", mode_o, 1);
    endtask

    initial begin
        t_reset();
        t_spi_capture();
        t_partial();
        t_extra_edges();
        t_quad_switch();
        t_tx_quad();
        t_tx_single();
        t_reset_broken();
        t_reset_single();
        t_reset_quad();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule